// File: doc/BRIEF.md
# Redundant Asynchronous Input Edge Capture

This block takes one asynchronous signal that reaches the chip as three redundant wires, which may switch a few clock cycles apart and one of which may be broken or briefly disturbed. Each wire is first brought into the local clock domain by a chain of flip-flops of its own. Only after that chain are the three copies combined by a two-out-of-three vote, so that the vote never sees a value that is still settling.

The voted level is passed on, and a rising-edge detector on it produces a pulse one clock wide for each rising edge of the signal. A mismatch flag shows, cycle by cycle, whether the three synchronised copies disagree. Logic that uses the signal can count the pulses as events and can watch the flag to see skew or a faulty wire.

Top module: `async_triple_capture`

## Requirements
- R1: While `rst_i` is 1, every synchroniser stage and the edge history register are cleared to 0. In the cycle after any clock edge that samples `rst_i` high, `level_o`, `rise_o` and `mismatch_o` are all 0.
- R2: Each copy passes through its own chain of SYNC_DEPTH flip-flops (default 2). If all three copies change together just after clock edge N, `level_o` shows the new value after edge N+2 and not before.
- R3: `level_o` is 1 exactly when at least two of the three synchronised copies are 1.
- R4: `rise_o` is 1 for exactly one cycle, the cycle in which `level_o` is 1 and was 0 in the cycle before. `rise_o` is never high in two consecutive cycles.
- R5: When the three copies rise with any skew from 0 to 2 clock cycles between them, `rise_o` pulses exactly once. When they later fall with the same kind of skew, `rise_o` does not pulse.
- R6: If any one copy is stuck at 0 or stuck at 1, each rising edge that the other two copies share still gives exactly one pulse on `rise_o`.
- R7: A pulse of one cycle on a single copy, with the other two steady, does not change `level_o` and gives no pulse on `rise_o`.
- R8: `mismatch_o` is 1 exactly while the synchronised copies are not all equal. For copies that switch d cycles apart (earliest to latest), it is high for d cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Capture clock |
| rst_i | input | 1 | Synchronous reset, active high |
| copies_i | input | 3 | The three asynchronous redundant copies of the input |
| level_o | output | 1 | Majority of the synchronised copies |
| rise_o | output | 1 | Pulse one cycle wide on each rising edge of `level_o` |
| mismatch_o | output | 1 | High while the synchronised copies disagree |

## Verification
Every combination of 0, 1 and 2 cycles of skew on each copy is swept for a rising and then a falling transition. This separates a correct single pulse from both a missed edge and a duplicate one, and the number of mismatch cycles is compared with the spread of the skews. Each copy in turn is held stuck at 0 and at 1 while the other two toggle, which shows whether the vote still lets their edges through. One-cycle glitches on a single copy, against a low and against a high background, check that a lone copy can neither create a pulse nor move the level. An aligned transition fixes the exact latency through the synchronisers.

// File: rtl/triple_capture_pkg.sv
package triple_capture_pkg;

   localparam int unsigned COPY_COUNT = 3;

   typedef logic [COPY_COUNT-1:0] copy_vec_t;

   // two-out-of-three majority
   function automatic logic vote2of3(input copy_vec_t v);
      return (v[0] & v[1]) | (v[1] & v[2]) | (v[0] & v[2]);
   endfunction

   // high when the copies are not unanimous
   function automatic logic copies_differ(input copy_vec_t v);
      return (v != '0) && (v != '1);
   endfunction

endpackage

// File: rtl/copy_synchronizer.sv
module copy_synchronizer #(
   parameter int unsigned DEPTH = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic async_i,
   output logic sync_o
);

   localparam int unsigned LAST = DEPTH - 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("copy_synchronizer: DEPTH must be at least 2");
      end
   endgenerate

   logic [LAST:0] stage_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         stage_q <= '0;
      end else begin
         stage_q <= {stage_q[LAST-1:0], async_i};
      end
   end

   assign sync_o = stage_q[LAST];

endmodule

// File: rtl/majority_voter.sv
module majority_voter
   import triple_capture_pkg::*;
(
   input  copy_vec_t votes_i,
   output logic      major_o,
   output logic      split_o
);

   always_comb begin
      major_o = vote2of3(votes_i);
      split_o = copies_differ(votes_i);
   end

endmodule

// File: rtl/rise_detector.sv
module rise_detector (
   input  logic clk_i,
   input  logic rst_i,
   input  logic level_i,
   output logic pulse_o
);

   logic hist_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         hist_q <= 1'b0;
      end else begin
         hist_q <= level_i;
      end
   end

   assign pulse_o = level_i & ~hist_q;

endmodule

// File: rtl/async_triple_capture.sv
module async_triple_capture
   import triple_capture_pkg::*;
#(
   parameter int unsigned SYNC_DEPTH = 2
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic [2:0] copies_i,
   output logic       level_o,
   output logic       rise_o,
   output logic       mismatch_o
);

   copy_vec_t synced_w;
   logic      voted_w;
   logic      split_w;

   generate
      for (genvar k = 0; k < COPY_COUNT; k++) begin : g_copy
         copy_synchronizer #(
            .DEPTH(SYNC_DEPTH)
         ) u_sync (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .async_i(copies_i[k]),
            .sync_o (synced_w[k])
         );
      end
   endgenerate

   majority_voter u_vote (
      .votes_i(synced_w),
      .major_o(voted_w),
      .split_o(split_w)
   );

   rise_detector u_edge (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .level_i(voted_w),
      .pulse_o(rise_o)
   );

   assign level_o    = voted_w;
   assign mismatch_o = split_w;

endmodule

// File: rtl/triple_capture_chk.sv
module triple_capture_chk (
   input logic       clk_i,
   input logic       rst_i,
   input logic [2:0] synced,
   input logic       level_o,
   input logic       rise_o,
   input logic       mismatch_o
);

   // R1
   reset_clears_chk: assert property (@(posedge clk_i)
      rst_i |=> (!level_o && !rise_o && !mismatch_o));

   // R3
   level_majority_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      level_o |-> ($countones(synced) >= 2));

   // R4
   pulse_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      rise_o |=> !rise_o);

   // R4
   pulse_on_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(level_o) |-> rise_o);

   // R4
   pulse_needs_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      rise_o |-> level_o);

   // R8
   agree_when_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !mismatch_o |-> ($countones(synced) == 0 || $countones(synced) == 3));

endmodule

bind async_triple_capture triple_capture_chk u_chk (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .synced    (synced_w),
   .level_o   (level_o),
   .rise_o    (rise_o),
   .mismatch_o(mismatch_o)
);

// File: tb/async_triple_capture_tb.sv
`timescale 1ns/1ps
module async_triple_capture_tb;

   logic       clk = 1'b0;
   logic       rst;
   logic [2:0] copies;
   logic       level, rise, mismatch;
   int         checks = 0;
   int         errors = 0;
   int         n_rise, n_mis, max_lvl;

   always #2 clk = ~clk;

   async_triple_capture u_dut (
      .clk_i(clk), .rst_i(rst), .copies_i(copies),
      .level_o(level), .rise_o(rise), .mismatch_o(mismatch)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // advance one edge; outputs then reflect that edge
   task automatic tick();
      @(posedge clk);
      #1;
      if (rise) n_rise++;
      if (mismatch) n_mis++;
      if (level) max_lvl = 1;
   endtask

   task automatic clear_counts();
      n_rise = 0; n_mis = 0; max_lvl = 0;
   endtask

   task automatic settle();
      for (int i = 0; i < 5; i++) tick();
   endtask

   initial begin
      #400000;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1;
      copies = 3'b111;
      tick(); tick();
      // R1: reset state
      check("R1 level", int'(level), 0);
      check("R1 rise", int'(rise), 0);
      check("R1 mismatch", int'(mismatch), 0);
      copies = 3'b000;
      rst = 1'b0;
      settle();

      // R2: aligned latency
      copies = 3'b111;
      tick();
      check("R2 level after 1 edge", int'(level), 0);
      tick();
      check("R2 level after 2 edges", int'(level), 1);
      check("R4 rise at first high cycle", int'(rise), 1);
      tick();
      check("R4 rise drops", int'(rise), 0);
      copies = 3'b000;
      settle();

      // R5/R8: full skew sweep
      for (int da = 0; da < 3; da++)
         for (int db = 0; db < 3; db++)
            for (int dc = 0; dc < 3; dc++) begin
               int mx, mn;
               mx = da; if (db > mx) mx = db; if (dc > mx) mx = dc;
               mn = da; if (db < mn) mn = db; if (dc < mn) mn = dc;
               clear_counts();
               for (int t = 0; t < 8; t++) begin
                  copies = {3'(t >= dc), 3'(t >= db), 3'(t >= da)} & 3'b111;
                  copies = {(t >= dc), (t >= db), (t >= da)};
                  tick();
               end
               check("R5 one pulse per skewed rise", n_rise, 1);
               check("R8 mismatch cycles on rise", n_mis, mx - mn);
               clear_counts();
               for (int t = 0; t < 8; t++) begin
                  copies = {(t < dc), (t < db), (t < da)};
                  tick();
               end
               check("R5 no pulse on skewed fall", n_rise, 0);
               check("R3 level low after fall", int'(level), 0);
            end

      // R6: one copy stuck
      for (int k = 0; k < 3; k++)
         for (int sv = 0; sv < 2; sv++) begin
            logic [2:0] stuck;
            stuck = 3'b001 << k;
            copies = sv ? stuck : 3'b000;
            settle();
            clear_counts();
            for (int e = 0; e < 3; e++) begin
               copies = sv ? 3'b111 : ~stuck;
               for (int i = 0; i < 4; i++) tick();
               copies = sv ? stuck : 3'b000;
               for (int i = 0; i < 4; i++) tick();
            end
            check("R6 edges through stuck copy", n_rise, 3);
            check("R8 mismatch while stuck disagrees", int'(n_mis > 0), 1);
         end

      // R7: single-copy glitch on low and high background
      for (int k = 0; k < 3; k++) begin
         copies = 3'b000;
         settle();
         clear_counts();
         copies = 3'b001 << k;
         tick();
         copies = 3'b000;
         settle();
         check("R7 no pulse from glitch", n_rise, 0);
         check("R7 level stays low", max_lvl, 0);
         check("R8 one mismatch cycle", n_mis, 1);
         copies = 3'b111;
         settle();
         clear_counts();
         copies = ~(3'b001 << k);
         tick();
         copies = 3'b111;
         settle();
         check("R7 no pulse from dropout", n_rise, 0);
         check("R7 level stays high", int'(level), 1);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule